// File: doc/BRIEF.md
# Serial SAR ADC Output Emulator

This block plays the converter side of a serial ADC link framed by chip select. A host drives an active-low chip select and a serial clock. The block takes a parallel sample word from elsewhere on the chip and shifts it out one bit at a time on a single data line. The frame follows the timing of a successive-approximation converter. Two leading zeros come first, then the result MSB first, then trailing zeros. An output-enable stands in for the line's three-state condition.

Chip select and serial clock belong to another clock domain. Each passes through a two-stage synchronizer clocked by the system clock, and the block finds edges by comparing successive synchronized values. Every response therefore appears three system clocks after the pin changes. A mode input picks a 12-bit or a 10-bit result. The block also reports when the converter would return to track mode, and it raises a flag when a frame is aborted early.

Top module: `sar_serial_emu`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `sdo_o` is 0, `track_o` is 1 and `abort_o` is 0.
- R2: A falling edge on `cs_ni` latches `sample_i` and `res10_i` for the frame, sets `sdo_oe_o` to 1 and `track_o` to 0, clears `abort_o`, and presents the first leading zero on `sdo_o`. Changes to `sample_i` later in the frame have no effect on it.
- R3: With `res10_i`=0 the frame is {2'b00, sample[11:0], 2'b00}, bit 15 first. After k falling edges of `sclk_i` (k from 0 to 15), `sdo_o` shows frame bit 15-k.
- R4: With `res10_i`=1 the frame is {2'b00, sample[9:0], 4'b0000}, bit 15 first, and `sample_i[11:10]` is ignored.
- R5: `track_o` stays 0 until the first rising edge of `sclk_i` that follows the 13th falling edge (12-bit mode) or the 11th falling edge (10-bit mode). From that rising edge on, it is 1.
- R6: If `cs_ni` rises after fewer than 14 falling edges (12-bit mode) or fewer than 12 (10-bit mode), the frame aborts. `sdo_oe_o` drops to 0, `track_o` becomes 1 and `abort_o` becomes 1.
- R7: The 16th falling edge sets `sdo_oe_o` to 0. Further falling edges while `cs_ni` stays low change nothing, and `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R8: If `cs_ni` rises after at least 14 falling edges (12-bit mode) or at least 12 (10-bit mode), the frame ends without setting `abort_o`, and `sdo_oe_o` drops to 0.
- R9: After an abort, `abort_o` stays 1 until the next falling edge of `cs_ni`. That frame sends a freshly latched sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select from the host, active low |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| sample_i | input | 12 | Parallel conversion result |
| res10_i | input | 1 | 1 selects 10-bit resolution, 0 selects 12-bit |
| sdo_o | output | 1 | Serial data, 0 when not driven |
| sdo_oe_o | output | 1 | 1 while the data line is driven; 0 stands for three-state |
| track_o | output | 1 | 1 in track mode, 0 while the sample is held |
| abort_o | output | 1 | Set by an early chip-select rise |

## Verification
The bench aims at the off-by-one edges. It aborts after exactly 13 falling edges in 12-bit mode and after exactly 11 in 10-bit mode, which must set the flag, and ends frames after exactly 14 and 12 edges, which must not. A design that counts one edge too many or too few flips one of those outcomes or moves the track point by a clock. Extra clocks after the 16th edge catch a counter that wraps and drives the line again. Changing the sample in the middle of a frame, and setting the upper bits in 10-bit mode, expose a design that reads the live input or uses the wrong bits of the sample.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;
  localparam int unsigned FRAME_LEN  = 16;
  localparam int unsigned LEAD_ZEROS = 2;
  localparam int unsigned RES_HI     = 12;
  localparam int unsigned RES_LO     = 10;
  localparam int unsigned CNT_W      = $clog2(FRAME_LEN + 1);

  typedef logic [CNT_W-1:0]     cnt_t;
  typedef logic [FRAME_LEN-1:0] frame_t;

  function automatic cnt_t need_clks(logic lo);
    return lo ? cnt_t'(LEAD_ZEROS + RES_LO) : cnt_t'(LEAD_ZEROS + RES_HI);
  endfunction

  function automatic frame_t build_frame(logic [RES_HI-1:0] s, logic lo);
    frame_t f;
    f = '0;
    if (lo) f[FRAME_LEN-LEAD_ZEROS-1 -: RES_LO] = s[RES_LO-1:0];
    else    f[FRAME_LEN-LEAD_ZEROS-1 -: RES_HI] = s;
    return f;
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_edge.sv
module sar_edge #(
  parameter int unsigned  W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/sar_frame.sv
module sar_frame
  import sar_emu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sclk_rise_i,
  input  logic [RES_HI-1:0] sample_i,
  input  logic              res10_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              track_o,
  output logic              abort_o
);
  frame_t shreg_q;
  cnt_t   cnt_q;
  logic   in_frame_q, oe_q, track_q, abort_q, res10_q;
  cnt_t   need;

  assign need = need_clks(res10_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      oe_q       <= 1'b0;
      track_q    <= 1'b1;
      abort_q    <= 1'b0;
      res10_q    <= 1'b0;
    end else if (cs_rise_i) begin
      if (in_frame_q && cnt_q < need) abort_q <= 1'b1;
      in_frame_q <= 1'b0;
      oe_q       <= 1'b0;
      track_q    <= 1'b1;
      shreg_q    <= '0;  // held sample dropped
    end else if (cs_fall_i) begin
      shreg_q    <= build_frame(sample_i, res10_i);
      res10_q    <= res10_i;
      cnt_q      <= '0;
      in_frame_q <= 1'b1;
      oe_q       <= 1'b1;
      track_q    <= 1'b0;
      abort_q    <= 1'b0;
    end else if (in_frame_q) begin
      if (sclk_fall_i && cnt_q < cnt_t'(FRAME_LEN)) begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= shreg_q << 1;
        if (cnt_q == cnt_t'(FRAME_LEN - 1)) oe_q <= 1'b0;
      end
      if (sclk_rise_i && !track_q && cnt_q >= need - 1'b1) track_q <= 1'b1;
    end
  end

  assign sdo_o    = shreg_q[FRAME_LEN-1] & oe_q;
  assign sdo_oe_o = oe_q;
  assign track_o  = track_q;
  assign abort_o  = abort_q;
endmodule

// File: rtl/sar_serial_emu.sv
module sar_serial_emu
  import sar_emu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [RES_HI-1:0] sample_i,
  input  logic              res10_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              track_o,
  output logic              abort_o
);
  logic [1:0] pins_s, rise, fall;

  // bit 1: chip select, bit 0: serial clock; both idle high
  sar_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i}),
    .q_o   (pins_s)
  );

  sar_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  sar_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (fall[1]),
    .cs_rise_i  (rise[1]),
    .sclk_fall_i(fall[0]),
    .sclk_rise_i(rise[0]),
    .sample_i   (sample_i),
    .res10_i    (res10_i),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .track_o    (track_o),
    .abort_o    (abort_o)
  );
endmodule

// File: rtl/sar_serial_emu_chk.sv
module sar_serial_emu_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic track_o,
  input logic abort_o
);
  // R7
  idle_line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  // R2
  start_enters_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $fell(track_o));

  // R2
  first_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> !sdo_o);

  // R6
  abort_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> (!sdo_oe_o && track_o));

  // R6
  abort_from_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> $past(sdo_oe_o));

  // R9
  abort_clear_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(abort_o) |-> $rose(sdo_oe_o));
endmodule

bind sar_serial_emu sar_serial_emu_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o),
  .track_o (track_o),
  .abort_o (abort_o)
);

// File: tb/sar_serial_emu_test.sv
`timescale 1ns/1ps
module sar_serial_emu_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, res10 = 1'b0;
  logic [11:0] sample = '0;
  logic sdo, sdo_oe, track, abort_f;

  always #10 clk = ~clk;  // 50 MHz

  sar_serial_emu uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sample_i(sample), .res10_i(res10),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .track_o(track), .abort_o(abort_f)
  );

  int errors = 0, checks = 0, age = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [15:0] m_word = '0;
  int m_cnt = 0, m_need = 14;
  bit m_in = 0, m_oe = 0, m_track = 1, m_abort = 0;

  function automatic bit exp_sdo();
    if (!m_oe || m_cnt > 15) return 1'b0;
    return m_word[15 - m_cnt];
  endfunction

  always @(negedge clk) begin
    if (rst_n && age >= 3) begin
      checks++;
      if (sdo_oe !== m_oe || sdo !== exp_sdo() || track !== m_track || abort_f !== m_abort) begin
        errors++;
        $display("FAIL %s t=%0t cnt=%0d: oe=%b sdo=%b track=%b abort=%b expected oe=%b sdo=%b track=%b abort=%b",
                 cur_req, $time, m_cnt, sdo_oe, sdo, track, abort_f, m_oe, exp_sdo(), m_track, m_abort);
      end
    end
    age++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired (%s) actual=hung expected=done", cur_req);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cs_low(logic [11:0] s, logic lo);
    sample = s; res10 = lo;
    wait_clk(1);
    cs_n = 1'b0; age = 0;
    m_word = lo ? {2'b00, s[9:0], 4'b0000} : {2'b00, s, 2'b00};
    m_need = lo ? 12 : 14;
    m_cnt = 0; m_in = 1; m_oe = 1; m_track = 0; m_abort = 0;
    wait_clk(4);
    sample = ~s;  // must not reach the frame
  endtask

  task automatic cs_high();
    cs_n = 1'b1; age = 0;
    if (m_in && m_cnt < m_need) m_abort = 1;
    m_in = 0; m_oe = 0; m_track = 1;
    wait_clk(5);
  endtask

  task automatic clocks(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; age = 0;
      if (m_in && m_cnt < 16) begin
        m_cnt++;
        if (m_cnt == 16) m_oe = 0;
      end
      wait_clk(4);
      sclk = 1'b1; age = 0;
      if (m_in && !m_track && m_cnt >= m_need - 1) m_track = 1;
      wait_clk(4);
    end
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1; age = 0;
    cur_req = "R1"; wait_clk(6);             // R1 idle state after reset

    cur_req = "R3"; cs_low(12'hA5C, 1'b0);   // R2 R3 R5 full 12-bit frame
    clocks(16);
    cur_req = "R7"; clocks(2);               // R7 extra clocks ignored
    cs_high();

    cur_req = "R4"; cs_low(12'hE96, 1'b1);   // R4 upper bits set, ignored
    clocks(16);
    cs_high();

    cur_req = "R8"; cs_low(12'h3C5, 1'b0);   // R8 14-clock frame, no abort
    clocks(14);
    cs_high();

    cur_req = "R6"; cs_low(12'hFFF, 1'b0);   // R6 abort after 5 clocks
    clocks(5);
    cs_high();
    wait_clk(4);
    cur_req = "R9"; cs_low(12'h812, 1'b0);   // R9 flag clears, fresh sample
    clocks(16);
    cs_high();

    cur_req = "R6"; cs_low(12'h7B1, 1'b0);   // R6 boundary: 13 clocks aborts
    clocks(13);
    cs_high();

    cur_req = "R6"; cs_low(12'h2AB, 1'b1);   // R6 boundary: 11 clocks in 10-bit
    clocks(11);
    cs_high();

    cur_req = "R8"; cs_low(12'h155, 1'b1);   // R8 R5 12 clocks in 10-bit
    clocks(12);
    cs_high();

    cur_req = "R2"; cs_low(12'h001, 1'b0);   // R2 sample changed mid-frame
    clocks(16);
    cs_high();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule